// File: doc/BRIEF.md
# Vertical-Sync Blink Generator

This block gates the drawing of characters that carry a blink attribute. It counts frames by detecting rising edges of the vertical sync input and keeps a frame count that runs over a period of either 32 or 64 frames. Within each period the first part is the visible phase and the remainder is the hidden phase. The split between them is a quarter, a half or three quarters of the period.

The character pipeline presents each character's blink attribute bit on `char_blink_i`. The block answers on `suppress_o`, which tells the glyph path to blank that character. The answer is combinational in the attribute and in the control field, and is registered only through the frame count. A 3-bit control field selects the period and the duty. One duty code turns blinking off entirely.

Top module: `vsync_blink_gate`

## Requirements
- R1: `vsync_i` passes through a two-stage synchronizer. The frame count advances exactly once for each rising edge of `vsync_i`, however long the input stays high, and the new count is in place at the third rising clock edge after `vsync_i` goes high.
- R2: `blink_ctrl_i[2]` selects the period. 0 selects 32 frames, so the count runs 0..31. 1 selects 64 frames, so the count runs 0..63. After the last value of the period, the next vsync edge returns the count to 0.
- R3: If the count is at or above the last value of the selected period when a vsync edge arrives (for example, after the period was cut from 64 to 32), the count goes to 0.
- R4: `blink_ctrl_i[1:0]` selects the visible share. 01 gives 25%, 10 gives 50% and 11 gives 75%. With blinking enabled and `char_blink_i` high, `suppress_o` is high exactly when the count is at or above that share of the period (8, 16 or 24 for 32 frames; 16, 32 or 48 for 64 frames).
- R5: When `blink_ctrl_i[1:0]` is 00, `suppress_o` stays low at every count. The frame count keeps running in this mode.
- R6: When `char_blink_i` is low, `suppress_o` is low.
- R7: An active-low `arst_n` forces the count to 0, which is the visible phase, so `suppress_o` is low during reset and just after it. Reset asserts asynchronously and releases synchronously.
- R8: `suppress_o` follows changes of `char_blink_i` and `blink_ctrl_i` in the same clock cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| vsync_i | input | 1 | Vertical sync, asynchronous, active high |
| blink_ctrl_i | input | 3 | Bit 2 selects the period; bits 1:0 select the duty |
| char_blink_i | input | 1 | Blink attribute of the current character |
| suppress_o | output | 1 | High means blank the current glyph |

## Verification
The frame count is not visible at the ports, so any fault in it shows up as `suppress_o` switching at the wrong frame. A step that is missed or doubled moves the first suppressed frame earlier or later. A wrong wrap point shifts every later visible phase. A bad threshold moves the edge between the visible and hidden phases. Each of these faults appears within one period of at most 64 vsync pulses. The bench therefore steps through complete periods in several duty and period modes, compares the output after every pulse, and also covers the case where the period shrinks while the count sits above the new last value.

// File: rtl/blink_pkg.sv
package blink_pkg;

  typedef enum logic [1:0] {
    DUTY_OFF  = 2'b00,
    DUTY_Q1   = 2'b01,
    DUTY_HALF = 2'b10,
    DUTY_Q3   = 2'b11
  } duty_e;

  typedef struct packed {
    logic  long_period;
    duty_e duty;
  } blink_cfg_t;

endpackage

// File: rtl/bg_reset_sync.sv
module bg_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/bg_vsync_edge.sv
module bg_vsync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vsync_i,
  output logic rise_o
);

  localparam int LEN = SYNC_STAGES + 1;

  logic [LEN-1:0] sh_q;
  logic [LEN-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[LEN-2:0], vsync_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

  // R1: one vsync edge gives one step pulse, never two back to back
  a_r1_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/bg_frame_counter.sv
module bg_frame_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             long_i,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'((1 << CNT_W) - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'((1 << (CNT_W - 1)) - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] last_val;
  logic             cnt_en;

  always_comb begin
    last_val = long_i ? LAST_LONG : LAST_SHORT;
    cnt_en   = step_i;
    if (cnt_q >= last_val) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  // R2: ordinary step inside the period
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && count_o < last_val) |=> count_o == $past(count_o) + 1'b1);

  // R3: at or past the last value the count wraps to zero
  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && count_o >= last_val) |=> count_o == '0);

  // R1: no vsync edge, no change
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(count_o));

endmodule

// File: rtl/bg_duty_compare.sv
module bg_duty_compare
  import blink_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic [CNT_W-1:0] count_i,
  input  blink_cfg_t       cfg_i,
  input  logic             char_blink_i,
  output logic             suppress_o
);

  localparam logic [CNT_W:0] QTR_SHORT = (CNT_W+1)'((1 << (CNT_W - 1)) / 4);
  localparam logic [CNT_W:0] QTR_LONG  = (CNT_W+1)'((1 << CNT_W) / 4);

  logic [CNT_W:0] quarter;
  logic [CNT_W:0] thresh;
  logic           hidden;

  always_comb begin
    quarter = cfg_i.long_period ? QTR_LONG : QTR_SHORT;
    unique case (cfg_i.duty)
      DUTY_Q1:   thresh = quarter;
      DUTY_HALF: thresh = quarter << 1;
      DUTY_Q3:   thresh = quarter + (quarter << 1);
      default:   thresh = '0;
    endcase
    hidden     = (cfg_i.duty != DUTY_OFF) && ({1'b0, count_i} >= thresh);
    suppress_o = hidden & char_blink_i;
  end

endmodule

// File: rtl/vsync_blink_gate.sv
module vsync_blink_gate
  import blink_pkg::*;
#(
  parameter int CNT_W       = 6,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       vsync_i,
  input  logic [2:0] blink_ctrl_i,
  input  logic       char_blink_i,
  output logic       suppress_o
);

  logic             rst_n;
  logic             step;
  logic [CNT_W-1:0] frame_cnt;
  blink_cfg_t       cfg;

  assign cfg = blink_cfg_t'(blink_ctrl_i);

  bg_reset_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  bg_vsync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .vsync_i (vsync_i),
    .rise_o  (step)
  );

  bg_frame_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_i  (step),
    .long_i  (cfg.long_period),
    .count_o (frame_cnt)
  );

  bg_duty_compare #(.CNT_W(CNT_W)) u_cmp (
    .count_i      (frame_cnt),
    .cfg_i        (cfg),
    .char_blink_i (char_blink_i),
    .suppress_o   (suppress_o)
  );

  // R5: duty code 00 never blanks
  a_r5_off_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.duty == DUTY_OFF) |-> !suppress_o);

  // R6: characters without the attribute are never blanked
  a_r6_no_attr: assert property (@(posedge clk) disable iff (!rst_n)
    !char_blink_i |-> !suppress_o);

  // R7: count zero is always the visible phase
  a_r7_zero_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_cnt == '0) |-> !suppress_o);

endmodule

// File: tb/test_vsync_blink_gate.sv
module test_vsync_blink_gate;

  logic       clk = 1'b0;
  logic       arst_n;
  logic       vsync_i;
  logic [2:0] blink_ctrl_i;
  logic       char_blink_i;
  logic       suppress_o;

  int errors = 0;
  int checks = 0;
  int cnt_m  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  vsync_blink_gate i_vsync_blink_gate (
    .clk          (clk),
    .arst_n       (arst_n),
    .vsync_i      (vsync_i),
    .blink_ctrl_i (blink_ctrl_i),
    .char_blink_i (char_blink_i),
    .suppress_o   (suppress_o)
  );

  function automatic bit model_sup();
    int q;
    q = blink_ctrl_i[2] ? 16 : 8;
    if (!char_blink_i || blink_ctrl_i[1:0] == 2'b00) return 1'b0;
    return cnt_m >= q * int'(blink_ctrl_i[1:0]);
  endfunction

  task automatic check(input string tag, input bit got, input bit exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: suppress_o=%0b expected %0b (frame %0d, ctrl %03b)",
               tag, got, exp, cnt_m, blink_ctrl_i);
    end
  endtask

  task automatic pulse(input int high_cycles);
    int last;
    @(negedge clk) vsync_i = 1'b1;
    repeat (high_cycles) @(negedge clk);
    vsync_i = 1'b0;
    repeat (3) @(negedge clk);
    last = blink_ctrl_i[2] ? 63 : 31;
    cnt_m = (cnt_m >= last) ? 0 : cnt_m + 1;
  endtask

  task automatic do_reset();
    @(negedge clk) arst_n = 1'b0;
    #2 check("R7 during reset", suppress_o, 1'b0);
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    cnt_m = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    blink_ctrl_i = 3'b001; char_blink_i = 1'b1; vsync_i = 1'b0;
    do_reset();
    check("R7 after reset", suppress_o, 1'b0);
  endtask

  task automatic t_sweep(input logic [2:0] ctrl, input string tag);
    int n;
    blink_ctrl_i = ctrl; char_blink_i = 1'b1;
    do_reset();
    n = ctrl[2] ? 128 : 64;
    for (int i = 0; i < n; i++) begin
      pulse(4);
      check(tag, suppress_o, model_sup());
    end
  endtask

  task automatic t_disabled();
    blink_ctrl_i = 3'b000; char_blink_i = 1'b1;
    do_reset();
    for (int i = 0; i < 20; i++) begin
      pulse(4);
      check("R5 duty off", suppress_o, 1'b0);
    end
    #2 blink_ctrl_i = 3'b001;
    #2 check("R5 counter kept running", suppress_o, model_sup());
  endtask

  task automatic t_attr();
    blink_ctrl_i = 3'b010; char_blink_i = 1'b0;
    do_reset();
    repeat (20) pulse(4);
    check("R6 no attribute", suppress_o, 1'b0);
    #2 char_blink_i = 1'b1;
    #2 check("R8 attribute same cycle", suppress_o, 1'b1);
    #2 blink_ctrl_i = 3'b011;
    #2 check("R8 duty same cycle", suppress_o, model_sup());
  endtask

  task automatic t_long_vsync();
    blink_ctrl_i = 3'b001; char_blink_i = 1'b1;
    do_reset();
    repeat (7) pulse(4);
    check("R1 before long pulse", suppress_o, 1'b0);
    pulse(40);
    check("R1 long pulse counts once", suppress_o, 1'b1);
    check("R1 model at 8", 1'(cnt_m == 8), 1'b1);
  endtask

  task automatic t_shorten();
    blink_ctrl_i = 3'b101; char_blink_i = 1'b1;
    do_reset();
    repeat (40) pulse(3);
    check("R3 at 40 long", suppress_o, model_sup());
    @(negedge clk) blink_ctrl_i = 3'b001;
    pulse(3);
    check("R3 shrink wraps to zero", suppress_o, 1'b0);
    check("R3 model wrapped", 1'(cnt_m == 0), 1'b1);
    repeat (8) pulse(3);
    check("R3 resumes after wrap", suppress_o, 1'b1);
  endtask

  task automatic t_midreset();
    blink_ctrl_i = 3'b001; char_blink_i = 1'b1;
    do_reset();
    repeat (20) pulse(3);
    check("R7 hidden before reset", suppress_o, 1'b1);
    do_reset();
    check("R7 reset restarts visible", suppress_o, 1'b0);
  endtask

  initial begin
    arst_n = 1'b1; vsync_i = 1'b0; blink_ctrl_i = 3'b000; char_blink_i = 1'b0;
    t_reset();
    t_sweep(3'b001, "R2 R4 32 frames 25%");
    t_sweep(3'b110, "R2 R4 64 frames 50%");
    t_sweep(3'b111, "R2 R4 64 frames 75%");
    t_sweep(3'b011, "R4 32 frames 75%");
    t_disabled();
    t_attr();
    t_long_vsync();
    t_shorten();
    t_midreset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule